// File: doc/BRIEF.md
# Interrupt Status and Coalescing Controller

This block gathers single-cycle event pulses from internal sources into a 32-bit host interrupt status word. The host clears status bits by writing ones to them. An enable mask picks which status bits may raise one host interrupt line.

A second status word holds per-channel DMA activity. It has two receive channels, two transmit channels, an error flag and a high-priority receive flag. Each DMA event also sets a summary bit in the main status word.

The interrupt line is held back by a coalescing timer that counts in 32 µs ticks. A high-priority receive event skips the wait and raises the line at once. A periodic timer can also post a receive interrupt on a fixed schedule. The 32 µs tick comes from a clock prescaler of `TICK_DIV` cycles. The host reaches everything through a single-cycle write strobe and a combinational read port.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset the main status, enable and DMA status words read 0, the interrupt line is low, and the configuration word reads 0x0000_0040 (timeout 0x40, periodic timer off).
- R2: An `evt_main` pulse sets the matching main status bit. A write to the main status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R3: When an event and a clearing write hit the same status bit in the same cycle, the bit ends set. Other bits cleared by that write still clear.
- R4: The line can rise only while some status bit is both set and enabled. A set bit that is not enabled never raises it.
- R5: With a timeout T other than 0, the line rises T*TICK_DIV+2 clock edges after the edge that captured the first enabled pending event.
- R6: With a timeout of 0, the line rises on the first clock edge after the edge that made an enabled bit pending.
- R7: The line falls one edge after the write that leaves no enabled bit pending. The timer then starts from zero at the next pending event.
- R8: DMA status bits exist only at these positions: 17 and 16 (receive channels 1 and 0), 1 and 0 (transmit channels 1 and 0), 31 (error) and 30 (high-priority receive). All other DMA bits read 0. DMA bits clear when written as 1.
- R9: A DMA event on bit 16, 17 or 30 sets main bit 31. A DMA event on bit 31 sets main bit 29. A DMA event on bit 0 or 1 sets main bit 27.
- R10: A DMA bit 30 event while main bit 31 is enabled raises the line on the next edge, whatever the timeout.
- R11: A periodic value P other than 0 sets main bit 28 every P*TICK_DIV edges, counted from the edge that wrote the configuration word. P = 0 never sets the bit.
- R12: Register map by `reg_addr`. Address 0 is configuration (bits 7:0 timeout, bits 15:8 periodic value). Address 1 is main status, address 2 is enable, and address 3 is DMA status. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_main | input | 32 | Event pulses setting main status bits |
| evt_dma | input | 32 | Event pulses setting DMA status bits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Host interrupt line |

## Verification
Two functions can land on the same status bit in one cycle: a hardware event setting the bit, and a host write-one-to-clear. The bench provokes this directly by driving an event pulse and a clearing write on the same bit in the same cycle, with a second bit cleared alongside it. It then also mixes random event words with random clear masks over many cycles. The expected word is `(old & ~clear) | event`, and the result is judged from the status read back after each cycle.

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl #(
  parameter int TICK_DIV = 1600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_main,
  input  logic [31:0] evt_dma,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [1:0] A_CFG = 2'd0, A_ST = 2'd1, A_EN = 2'd2, A_DMA = 2'd3;
  localparam int DMA_ERR = 31, DMA_HP = 30;
  localparam logic [31:0] DMA_RX  = 32'h4003_0000;
  localparam logic [31:0] DMA_TX  = 32'h0000_0003;
  localparam logic [31:0] DMA_IMP = 32'hC003_0003;
  localparam int SUM_RX = 31, SUM_ERR = 29, PER_BIT = 28, SUM_TX = 27;

  logic [31:0] st_q, en_q, dma_q, st_clr, dma_clr, st_set;
  logic [7:0]  coal_to, per_val, co_tick, per_tick;
  logic [PRE_W-1:0] co_pre, per_pre;
  logic co_act, co_done, hp_q, irq_q, pending, cfg_wr, per_on, per_wrap, per_fire;

  assign cfg_wr  = reg_wr && (reg_addr == A_CFG);
  assign st_clr  = (reg_wr && reg_addr == A_ST)  ? reg_wdata : 32'd0;
  assign dma_clr = (reg_wr && reg_addr == A_DMA) ? reg_wdata : 32'd0;
  assign pending = |(st_q & en_q);
  assign co_done = co_act && (co_tick >= coal_to);
  assign per_on   = per_val != 8'd0;
  assign per_wrap = per_pre == PRE_LAST;
  assign per_fire = per_on && per_wrap && (per_tick == per_val - 8'd1);
  assign irq = irq_q;

  always_comb begin
    st_set = evt_main;
    st_set[SUM_RX]  = st_set[SUM_RX]  | (|(evt_dma & DMA_RX));
    st_set[SUM_ERR] = st_set[SUM_ERR] | evt_dma[DMA_ERR];
    st_set[SUM_TX]  = st_set[SUM_TX]  | (|(evt_dma & DMA_TX));
    st_set[PER_BIT] = st_set[PER_BIT] | per_fire;
  end

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {16'd0, per_val, coal_to};
      A_ST:    reg_rdata = st_q;
      A_EN:    reg_rdata = en_q;
      default: reg_rdata = dma_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      en_q    <= '0;
      dma_q   <= '0;
      coal_to <= 8'h40;
      per_val <= 8'h00;
    end else begin
      st_q  <= (st_q & ~st_clr) | st_set;
      dma_q <= (dma_q & ~dma_clr) | (evt_dma & DMA_IMP);
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata;
      if (cfg_wr) begin
        coal_to <= reg_wdata[7:0];
        per_val <= reg_wdata[15:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      co_act  <= 1'b0;
      co_pre  <= '0;
      co_tick <= '0;
    end else if (!pending) begin
      co_act  <= 1'b0;
      co_pre  <= '0;
      co_tick <= '0;
    end else if (!co_act) begin
      co_act  <= 1'b1;
      co_pre  <= '0;
      co_tick <= '0;
    end else if (co_pre == PRE_LAST) begin
      co_pre <= '0;
      if (co_tick != 8'hFF) co_tick <= co_tick + 8'd1;
    end else begin
      co_pre <= co_pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (evt_dma[DMA_HP] && en_q[SUM_RX]) hp_q <= 1'b1;
      else if (!pending)                   hp_q <= 1'b0;
      irq_q <= pending && (coal_to == 8'd0 || co_done || hp_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_pre  <= '0;
      per_tick <= '0;
    end else if (cfg_wr || !per_on) begin
      per_pre  <= '0;
      per_tick <= '0;
    end else if (per_wrap) begin
      per_pre  <= '0;
      per_tick <= per_fire ? 8'd0 : per_tick + 8'd1;
    end else begin
      per_pre <= per_pre + 1'b1;
    end
  end

  // R2
  w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(st_q) & ~st_q & ~$past(st_clr)) == 32'd0));
  // R4
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(pending));
  // R6
  zero_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coal_to == 8'd0 && pending) |=> irq_q);
  // R9
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dma[DMA_ERR] |=> st_q[SUM_ERR]);
  // R10
  hp_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_dma[DMA_HP] && en_q[SUM_RX] && !(reg_wr && reg_addr == A_EN)) |=> ##1 irq_q);
endmodule

// File: tb/irq_coalesce_ctrl_test.sv
module irq_coalesce_ctrl_test;
  localparam int D = 4;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, irq;
  logic [31:0] evt_main = '0, evt_dma = '0, reg_wdata = '0, reg_rdata;
  logic [1:0] reg_addr = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_coalesce_ctrl #(.TICK_DIV(D)) uut (.clk(clk), .rst_n(rst_n), .evt_main(evt_main),
    .evt_dma(evt_dma), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  always #10 clk = ~clk;

  function automatic logic [31:0] f_w1c(logic [31:0] old, logic [31:0] clr, logic [31:0] set);
    return (old & ~clr) | set;
  endfunction
  function automatic logic [31:0] f_sum(logic [31:0] d);
    logic [31:0] s = '0;
    s[31] = d[16] | d[17] | d[30];
    s[29] = d[31];
    s[27] = d[0] | d[1];
    return s;
  endfunction
  function automatic int f_lat(int t);
    return (t == 0) ? 1 : t * D + 2;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask
  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic pulse(logic [31:0] m, logic [31:0] dm);
    evt_main = m; evt_dma = dm;
    tick(1);
    evt_main = '0; evt_dma = '0;
  endtask
  task automatic latency(output int k);
    k = 0;
    while (!irq && k < 2000) begin tick(1); k++; end
  endtask
  task automatic clear_all();
    wr(2'd1, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] v, exp, ev, cl;
    int k;
    void'($urandom(32'd20240611));
    tick(2); rst_n = 1'b1; tick(1);
    // R1 R12
    rd(2'd0, v); chk("R1", v, 32'h0000_0040);
    rd(2'd1, v); chk("R1", v, 0);
    rd(2'd2, v); chk("R1", v, 0);
    rd(2'd3, v); chk("R1", v, 0);
    chk("R1", irq, 0);
    // R2
    pulse(32'h20, 0);
    rd(2'd1, v); chk("R2", v, 32'h20);
    wr(2'd1, 32'h0); rd(2'd1, v); chk("R2", v, 32'h20);
    wr(2'd1, 32'h20); rd(2'd1, v); chk("R2", v, 32'h0);
    // R3
    pulse(32'h18, 0);
    evt_main = 32'h8; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h18;
    tick(1);
    evt_main = '0; reg_wr = 1'b0;
    rd(2'd1, v); chk("R3", v, 32'h8);
    exp = 32'h8;
    for (int i = 0; i < 200; i++) begin
      ev = $urandom & $urandom; cl = $urandom;
      evt_main = ev; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = cl;
      tick(1);
      evt_main = '0; reg_wr = 1'b0;
      exp = f_w1c(exp, cl, ev);
      rd(2'd1, v); chk("R3 R2 random", v, exp);
    end
    clear_all();
    // R4 R6 R7
    wr(2'd2, 32'h10);
    pulse(32'h80, 0);
    tick(20); chk("R4 masked", irq, 0);
    wr(2'd0, 32'h0);
    pulse(32'h10, 0);
    latency(k); chk("R6", k, f_lat(0));
    wr(2'd1, 32'h10); chk("R7 hold", irq, 1);
    tick(1); chk("R7 fall", irq, 0);
    wr(2'd1, 32'h80);
    // R5
    foreach (exp[i]) if (i < 5) begin
      int t;
      t = (i == 0) ? 1 : (i == 1) ? 3 : (i == 2) ? 8'h40 : 1 + ($urandom % 20);
      wr(2'd0, t);
      pulse(32'h10, 0);
      latency(k); chk("R5 R7", k, f_lat(t));
      wr(2'd1, 32'h10); tick(1);
    end
    wr(2'd2, 32'h0);
    // R8 R9
    pulse(0, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R8", v, 32'hC003_0003);
    rd(2'd1, v); chk("R9", v, f_sum(32'hFFFF_FFFF));
    wr(2'd3, 32'h1); rd(2'd3, v); chk("R8 w1c", v, 32'hC003_0002);
    clear_all();
    pulse(0, 32'h0000_FFFC & $urandom);
    rd(2'd3, v); chk("R8 unimpl", v, 0);
    rd(2'd1, v); chk("R9 unimpl", v, 0);
    foreach (exp[i]) if (i < 6) begin
      ev = (i == 0) ? 32'h1 : (i == 1) ? 32'h2 : (i == 2) ? 32'h1_0000 :
           (i == 3) ? 32'h2_0000 : (i == 4) ? 32'h8000_0000 : 32'h4000_0000;
      pulse(0, ev);
      rd(2'd1, v); chk("R9", v, f_sum(ev));
      rd(2'd3, v); chk("R8", v, ev);
      clear_all();
    end
    // R10
    wr(2'd0, 32'h40); wr(2'd2, 32'h8000_0000);
    pulse(0, 32'h4000_0000);
    latency(k); chk("R10 bypass", k, 1);
    clear_all(); tick(1);
    wr(2'd0, 32'h2);
    pulse(0, 32'h1_0000);
    latency(k); chk("R10 normal rx", k, f_lat(2));
    clear_all(); wr(2'd2, 32'h0);
    // R11
    wr(2'd0, 32'h0300);
    tick(3 * D - 1); rd(2'd1, v); chk("R11 early", v[28], 0);
    tick(1); rd(2'd1, v); chk("R11 fire", v[28], 1);
    wr(2'd1, 32'h1000_0000);
    tick(3 * D - 2); rd(2'd1, v); chk("R11 early2", v[28], 0);
    tick(1); rd(2'd1, v); chk("R11 repeat", v[28], 1);
    wr(2'd0, 32'h0000); wr(2'd1, 32'h1000_0000);
    tick(50); rd(2'd1, v); chk("R11 off", v[28], 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule